// File: doc/BRIEF.md
# Register Rename and Dispatch Stage

This stage sits between decode and the functional units of a small out-of-order core. The core has four logical registers and a pool of eight hidden registers. Only the hidden registers hold data. Each logical register is a pointer into the pool.

Up to two decoded instructions arrive per cycle. For each one, the stage does three things:
- It reads the current pointers of both sources.
- It gives the destination a fresh hidden register, which removes write-after-write and write-after-read hazards.
- One cycle later, it emits a dispatch packet naming the functional unit, the two operand sources and the result register.

An operand source is tagged. It names either a hidden register whose value is already present, or the functional unit (multiply, divide, add/subtract) that will deliver the value.

A writeback port marks a hidden register as holding its value. An in-order commit port records the new architectural mapping of a logical register and hands the mapping it replaces back to the free pool.

Top module: `rename_dispatch`

## Requirements
- R1: After reset, logical register Ri points to hidden register Si (i = 0..3), S0–S3 hold data and are the committed mappings, S4–S7 are free, and no dispatch slot is valid.
- R2: An operand is encoded as 4 bits {pend, idx[2:0]}; when the mapped hidden register already holds its value, the field is {0, hidden register index}.
- R3: When the mapped hidden register is still awaited, the field is {1, unit}, where unit is the code of the unit that produces it: 0 multiply, 1 divide, 2 add/subtract.
- R4: Each accepted instruction receives the lowest-numbered free hidden register, with slot 0 served before slot 1, and the result field carries that index.
- R5: Sources are read before the destination pointer moves, so an instruction whose source and destination are the same logical register sees the earlier mapping.
- R6: When slot 1 reads a logical register that slot 0 of the same group writes, slot 1's operand is {1, unit of slot 0}.
- R7: A writeback of a hidden register in the same cycle that a source maps to it yields the {0, index} form.
- R8: dec_ready_o is low exactly when the free pool holds fewer registers than the group has valid slots; such a group is not accepted, produces no packet, and leaves the mappings and the pool unchanged.
- R9: A commit returns the previously committed hidden register of that logical register to the pool, where it becomes usable from the next cycle, not the cycle of the commit.
- R10: A packet appears in the cycle after acceptance, with disp_valid_o set per valid slot and the unit field copied from decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dec_valid_i | input | 2 | Per-slot valid of the decode group |
| dec_fu_i | input | 2x2 | Per-slot unit code (0 mul, 1 div, 2 add/sub) |
| dec_src1_i | input | 2x2 | Per-slot first source logical register |
| dec_src2_i | input | 2x2 | Per-slot second source logical register |
| dec_dst_i | input | 2x2 | Per-slot destination logical register |
| dec_ready_o | output | 1 | Group accepted this cycle when high |
| wb_valid_i | input | 1 | A hidden register received its value |
| wb_preg_i | input | 3 | Index of that hidden register |
| cmt_valid_i | input | 1 | Commit of the oldest renamed instruction |
| cmt_lreg_i | input | 2 | Logical register being committed |
| cmt_preg_i | input | 3 | Hidden register that becomes its committed mapping |
| disp_valid_o | output | 2 | Per-slot packet valid |
| disp_fu_o | output | 2x2 | Per-slot target unit |
| disp_op1_o | output | 2x4 | Per-slot first operand source {pend, idx} |
| disp_op2_o | output | 2x4 | Per-slot second operand source {pend, idx} |
| disp_res_o | output | 2x3 | Per-slot result hidden register |

## Verification
Rename can coincide with writeback: a source read in the same cycle that its hidden register receives its value. The bench schedules writebacks of exactly the registers that the current group reads, and expects the register form of the operand rather than the unit tag.

Rename can also coincide with commit. While the pool is empty, a commit that frees a register is paired with a rename request in the same cycle. The bench expects the stall to persist for that cycle and the freed register to be handed out in the next one.

A long pseudo-random sweep mixes both overlaps with intra-group forwarding. A model in the bench predicts every packet field.

// File: rtl/rn_pkg.sv
package rn_pkg;
  parameter int unsigned NUM_LOG  = 4;
  parameter int unsigned NUM_PHYS = 8;
  parameter int unsigned NUM_FU   = 3;
  parameter int unsigned RN_W     = 2;

  localparam int unsigned LW = $clog2(NUM_LOG);
  localparam int unsigned PW = $clog2(NUM_PHYS);
  localparam int unsigned FW = $clog2(NUM_FU);
  localparam int unsigned CW = $clog2(NUM_PHYS + 1);
  localparam int unsigned NW = $clog2(RN_W + 1);

  typedef logic [LW-1:0] lreg_t;
  typedef logic [PW-1:0] preg_t;
  typedef logic [FW-1:0] fu_t;

  // operand source: pend=0 -> hidden register, pend=1 -> producing unit
  typedef struct packed {
    logic  pend;
    preg_t idx;
  } opsrc_t;

  localparam fu_t FU_MUL = fu_t'(0);
  localparam fu_t FU_DIV = fu_t'(1);
  localparam fu_t FU_ADD = fu_t'(2);
endpackage

// File: rtl/rn_free_pool.sv
module rn_free_pool
  import rn_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   alloc_en_i,
  input  logic [RN_W-1:0]        alloc_req_i,
  input  logic                   rel_valid_i,
  input  preg_t                  rel_preg_i,
  output preg_t [RN_W-1:0]       alloc_preg_o,
  output logic [NUM_PHYS-1:0]    free_mask_o,
  output logic [CW-1:0]          free_cnt_o
);
  localparam logic [NUM_PHYS-1:0] RST_FREE = {NUM_PHYS{1'b1}} << NUM_LOG;

  logic [NUM_PHYS-1:0] free_q, free_d, avail_end;

  // chained lowest-first pick: each slot sees what earlier slots left
  always_comb begin
    logic [NUM_PHYS-1:0] av;
    av = free_q;
    for (int k = 0; k < RN_W; k++) begin
      alloc_preg_o[k] = '0;
      for (int i = NUM_PHYS - 1; i >= 0; i--) begin
        if (av[i]) alloc_preg_o[k] = preg_t'(i);
      end
      if (alloc_req_i[k]) av[alloc_preg_o[k]] = 1'b0;
    end
    avail_end = av;
  end

  always_comb begin
    free_d = alloc_en_i ? avail_end : free_q;
    if (rel_valid_i) free_d[rel_preg_i] = 1'b1;
  end

  always_comb begin
    free_cnt_o = '0;
    for (int i = 0; i < NUM_PHYS; i++) free_cnt_o = free_cnt_o + CW'(free_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_q <= RST_FREE;
    else         free_q <= free_d;
  end

  assign free_mask_o = free_q;
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table
  import rn_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                upd_en_i,
  input  logic [RN_W-1:0]     valid_i,
  input  fu_t   [RN_W-1:0]    fu_i,
  input  lreg_t [RN_W-1:0]    src1_i,
  input  lreg_t [RN_W-1:0]    src2_i,
  input  lreg_t [RN_W-1:0]    dst_i,
  input  preg_t [RN_W-1:0]    new_preg_i,
  output preg_t [RN_W-1:0]    s1_preg_o,
  output preg_t [RN_W-1:0]    s2_preg_o,
  output logic  [RN_W-1:0]    s1_fresh_o,
  output logic  [RN_W-1:0]    s2_fresh_o,
  output fu_t   [RN_W-1:0]    s1_fu_o,
  output fu_t   [RN_W-1:0]    s2_fu_o
);
  preg_t map_q [NUM_LOG];

  // lookup uses the pre-update table; older slots of the group forward
  always_comb begin
    for (int k = 0; k < RN_W; k++) begin
      s1_preg_o[k]  = map_q[src1_i[k]];
      s2_preg_o[k]  = map_q[src2_i[k]];
      s1_fresh_o[k] = 1'b0;
      s2_fresh_o[k] = 1'b0;
      s1_fu_o[k]    = '0;
      s2_fu_o[k]    = '0;
      for (int j = 0; j < k; j++) begin
        if (valid_i[j] && dst_i[j] == src1_i[k]) begin
          s1_preg_o[k]  = new_preg_i[j];
          s1_fresh_o[k] = 1'b1;
          s1_fu_o[k]    = fu_i[j];
        end
        if (valid_i[j] && dst_i[j] == src2_i[k]) begin
          s2_preg_o[k]  = new_preg_i[j];
          s2_fresh_o[k] = 1'b1;
          s2_fu_o[k]    = fu_i[j];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_LOG; i++) map_q[i] <= preg_t'(i);
    end else if (upd_en_i) begin
      for (int k = 0; k < RN_W; k++) begin
        if (valid_i[k]) map_q[dst_i[k]] <= new_preg_i[k];
      end
    end
  end
endmodule

// File: rtl/rn_preg_status.sv
module rn_preg_status
  import rn_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   alloc_en_i,
  input  logic [RN_W-1:0]        alloc_req_i,
  input  preg_t [RN_W-1:0]       alloc_preg_i,
  input  fu_t   [RN_W-1:0]       alloc_fu_i,
  input  logic                   wb_valid_i,
  input  preg_t                  wb_preg_i,
  output logic [NUM_PHYS-1:0]    ready_o,
  output fu_t  [NUM_PHYS-1:0]    prod_fu_o
);
  localparam logic [NUM_PHYS-1:0] RST_RDY = ~({NUM_PHYS{1'b1}} << NUM_LOG);

  logic [NUM_PHYS-1:0] ready_q;
  fu_t  [NUM_PHYS-1:0] prod_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= RST_RDY;
      prod_q  <= '0;
    end else begin
      if (wb_valid_i) ready_q[wb_preg_i] <= 1'b1;
      if (alloc_en_i) begin
        for (int k = 0; k < RN_W; k++) begin
          if (alloc_req_i[k]) begin
            ready_q[alloc_preg_i[k]] <= 1'b0;
            prod_q[alloc_preg_i[k]]  <= alloc_fu_i[k];
          end
        end
      end
    end
  end

  assign ready_o   = ready_q;
  assign prod_fu_o = prod_q;
endmodule

// File: rtl/rn_commit_map.sv
module rn_commit_map
  import rn_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cmt_valid_i,
  input  lreg_t cmt_lreg_i,
  input  preg_t cmt_preg_i,
  output logic  rel_valid_o,
  output preg_t rel_preg_o
);
  preg_t cmap_q [NUM_LOG];

  assign rel_valid_o = cmt_valid_i;
  assign rel_preg_o  = cmap_q[cmt_lreg_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_LOG; i++) cmap_q[i] <= preg_t'(i);
    end else if (cmt_valid_i) begin
      cmap_q[cmt_lreg_i] <= cmt_preg_i;
    end
  end
endmodule

// File: rtl/rename_dispatch.sv
module rename_dispatch
  import rn_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [RN_W-1:0]          dec_valid_i,
  input  logic [RN_W-1:0][FW-1:0]  dec_fu_i,
  input  logic [RN_W-1:0][LW-1:0]  dec_src1_i,
  input  logic [RN_W-1:0][LW-1:0]  dec_src2_i,
  input  logic [RN_W-1:0][LW-1:0]  dec_dst_i,
  output logic                     dec_ready_o,
  input  logic                     wb_valid_i,
  input  logic [PW-1:0]            wb_preg_i,
  input  logic                     cmt_valid_i,
  input  logic [LW-1:0]            cmt_lreg_i,
  input  logic [PW-1:0]            cmt_preg_i,
  output logic [RN_W-1:0]          disp_valid_o,
  output logic [RN_W-1:0][FW-1:0]  disp_fu_o,
  output logic [RN_W-1:0][PW:0]    disp_op1_o,
  output logic [RN_W-1:0][PW:0]    disp_op2_o,
  output logic [RN_W-1:0][PW-1:0]  disp_res_o
);
  preg_t [RN_W-1:0]    alloc_preg;
  logic [NUM_PHYS-1:0] free_mask;
  logic [CW-1:0]       free_cnt;
  logic [NW-1:0]       need;
  logic                accept;
  logic                rel_valid;
  preg_t               rel_preg;

  preg_t [RN_W-1:0]    s1_preg, s2_preg;
  logic  [RN_W-1:0]    s1_fresh, s2_fresh;
  fu_t   [RN_W-1:0]    s1_fu, s2_fu;
  logic [NUM_PHYS-1:0] ready;
  fu_t  [NUM_PHYS-1:0] prod_fu;
  opsrc_t [RN_W-1:0]   op1, op2;

  always_comb begin
    need = '0;
    for (int k = 0; k < RN_W; k++) need = need + NW'(dec_valid_i[k]);
  end

  // whole group or nothing
  assign dec_ready_o = free_cnt >= CW'(need);
  assign accept      = (|dec_valid_i) && dec_ready_o;

  rn_free_pool u_pool (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_en_i  (accept),
    .alloc_req_i (dec_valid_i),
    .rel_valid_i (rel_valid),
    .rel_preg_i  (rel_preg),
    .alloc_preg_o(alloc_preg),
    .free_mask_o (free_mask),
    .free_cnt_o  (free_cnt)
  );

  rn_map_table u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_en_i  (accept),
    .valid_i   (dec_valid_i),
    .fu_i      (dec_fu_i),
    .src1_i    (dec_src1_i),
    .src2_i    (dec_src2_i),
    .dst_i     (dec_dst_i),
    .new_preg_i(alloc_preg),
    .s1_preg_o (s1_preg),
    .s2_preg_o (s2_preg),
    .s1_fresh_o(s1_fresh),
    .s2_fresh_o(s2_fresh),
    .s1_fu_o   (s1_fu),
    .s2_fu_o   (s2_fu)
  );

  rn_preg_status u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_en_i  (accept),
    .alloc_req_i (dec_valid_i),
    .alloc_preg_i(alloc_preg),
    .alloc_fu_i  (dec_fu_i),
    .wb_valid_i  (wb_valid_i),
    .wb_preg_i   (wb_preg_i),
    .ready_o     (ready),
    .prod_fu_o   (prod_fu)
  );

  rn_commit_map u_cmap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmt_valid_i(cmt_valid_i),
    .cmt_lreg_i (cmt_lreg_i),
    .cmt_preg_i (cmt_preg_i),
    .rel_valid_o(rel_valid),
    .rel_preg_o (rel_preg)
  );

  // tag formation; same-cycle writeback counts as present
  always_comb begin
    for (int k = 0; k < RN_W; k++) begin
      if (s1_fresh[k])
        op1[k] = '{pend: 1'b1, idx: preg_t'(s1_fu[k])};
      else if (ready[s1_preg[k]] || (wb_valid_i && wb_preg_i == s1_preg[k]))
        op1[k] = '{pend: 1'b0, idx: s1_preg[k]};
      else
        op1[k] = '{pend: 1'b1, idx: preg_t'(prod_fu[s1_preg[k]])};

      if (s2_fresh[k])
        op2[k] = '{pend: 1'b1, idx: preg_t'(s2_fu[k])};
      else if (ready[s2_preg[k]] || (wb_valid_i && wb_preg_i == s2_preg[k]))
        op2[k] = '{pend: 1'b0, idx: s2_preg[k]};
      else
        op2[k] = '{pend: 1'b1, idx: preg_t'(prod_fu[s2_preg[k]])};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_valid_o <= '0;
      disp_fu_o    <= '0;
      disp_op1_o   <= '0;
      disp_op2_o   <= '0;
      disp_res_o   <= '0;
    end else begin
      disp_valid_o <= accept ? dec_valid_i : '0;
      if (accept) begin
        disp_fu_o  <= dec_fu_i;
        disp_op1_o <= op1;
        disp_op2_o <= op2;
        disp_res_o <= alloc_preg;
      end
    end
  end
endmodule

// File: rtl/rename_dispatch_chk.sv
module rename_dispatch_chk
  import rn_pkg::*;
(
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [RN_W-1:0]         dec_valid_i,
  input logic                    dec_ready_o,
  input logic [RN_W-1:0]         disp_valid_o,
  input logic [RN_W-1:0][PW-1:0] disp_res_o,
  input logic [NUM_PHYS-1:0]     free_mask_i,
  input preg_t [RN_W-1:0]        alloc_preg_i
);
  assert_no_packet_on_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_o != '0) |-> $past(dec_ready_o));

  assert_free_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(free_mask_i) <= NUM_PHYS - NUM_LOG);

  for (genvar k = 0; k < RN_W; k++) begin : g_slot
    assert_alloc_from_free_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_valid_i[k] && dec_ready_o) |-> free_mask_i[alloc_preg_i[k]]);

    assert_packet_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disp_valid_o[k] |-> $past(dec_valid_i[k] && dec_ready_o));
  end

  if (RN_W > 1) begin : g_pair
    assert_distinct_result_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (disp_valid_o[0] && disp_valid_o[1]) |-> (disp_res_o[0] != disp_res_o[1]));
  end
endmodule

bind rename_dispatch rename_dispatch_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dec_valid_i (dec_valid_i),
  .dec_ready_o (dec_ready_o),
  .disp_valid_o(disp_valid_o),
  .disp_res_o  (disp_res_o),
  .free_mask_i (free_mask),
  .alloc_preg_i(alloc_preg)
);

// File: tb/rename_dispatch_tb.sv
`timescale 1ns/1ps
module rename_dispatch_tb;
  import rn_pkg::*;

  logic                     clk = 1'b0;
  logic                     rst_ni = 1'b0;
  logic [RN_W-1:0]          dec_valid_i = '0;
  logic [RN_W-1:0][FW-1:0]  dec_fu_i = '0;
  logic [RN_W-1:0][LW-1:0]  dec_src1_i = '0;
  logic [RN_W-1:0][LW-1:0]  dec_src2_i = '0;
  logic [RN_W-1:0][LW-1:0]  dec_dst_i = '0;
  logic                     dec_ready_o;
  logic                     wb_valid_i = 1'b0;
  logic [PW-1:0]            wb_preg_i = '0;
  logic                     cmt_valid_i = 1'b0;
  logic [LW-1:0]            cmt_lreg_i = '0;
  logic [PW-1:0]            cmt_preg_i = '0;
  logic [RN_W-1:0]          disp_valid_o;
  logic [RN_W-1:0][FW-1:0]  disp_fu_o;
  logic [RN_W-1:0][PW:0]    disp_op1_o;
  logic [RN_W-1:0][PW:0]    disp_op2_o;
  logic [RN_W-1:0][PW-1:0]  disp_res_o;

  always #4 clk = ~clk;

  rename_dispatch u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .dec_valid_i(dec_valid_i), .dec_fu_i(dec_fu_i),
    .dec_src1_i(dec_src1_i), .dec_src2_i(dec_src2_i), .dec_dst_i(dec_dst_i),
    .dec_ready_o(dec_ready_o),
    .wb_valid_i(wb_valid_i), .wb_preg_i(wb_preg_i),
    .cmt_valid_i(cmt_valid_i), .cmt_lreg_i(cmt_lreg_i), .cmt_preg_i(cmt_preg_i),
    .disp_valid_o(disp_valid_o), .disp_fu_o(disp_fu_o),
    .disp_op1_o(disp_op1_o), .disp_op2_o(disp_op2_o), .disp_res_o(disp_res_o)
  );

  int  errs = 0;
  int  checks = 0;
  bit  done = 1'b0;

  // reference state
  int  m_map  [NUM_LOG];
  int  m_cmap [NUM_LOG];
  bit  m_free [NUM_PHYS];
  bit  m_rdy  [NUM_PHYS];
  int  m_fu   [NUM_PHYS];
  int  ql [64];
  int  qp [64];
  int  qh = 0;
  int  qt = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NUM_LOG; i++) begin m_map[i] = i; m_cmap[i] = i; end
    for (int i = 0; i < NUM_PHYS; i++) begin
      m_free[i] = (i >= NUM_LOG);
      m_rdy[i]  = (i < NUM_LOG);
      m_fu[i]   = 0;
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic [1:0] v,
                      input int fu0, input int a0, input int b0, input int d0,
                      input int fu1, input int a1, input int b1, input int d1,
                      input bit wbv, input int wbp, input bit cmv, input string rq);
    int fu[2], sa[2], sb[2], dd[2];
    int e1[2], e2[2], er[2];
    int fr[NUM_LOG];
    int tmap[NUM_LOG];
    bit tf[NUM_PHYS];
    int need, fc, cl, cp;
    bit exp_rdy, do_cmt;
    fu[0] = fu0; sa[0] = a0; sb[0] = b0; dd[0] = d0;
    fu[1] = fu1; sa[1] = a1; sb[1] = b1; dd[1] = d1;
    for (int k = 0; k < 2; k++) begin
      dec_fu_i[k]   = FW'(fu[k]);
      dec_src1_i[k] = LW'(sa[k]);
      dec_src2_i[k] = LW'(sb[k]);
      dec_dst_i[k]  = LW'(dd[k]);
    end
    dec_valid_i = v;
    wb_valid_i  = wbv;
    wb_preg_i   = PW'(wbp);
    do_cmt = cmv && (qh != qt);
    cl = do_cmt ? ql[qh % 64] : 0;
    cp = do_cmt ? qp[qh % 64] : 0;
    cmt_valid_i = do_cmt;
    cmt_lreg_i  = LW'(cl);
    cmt_preg_i  = PW'(cp);

    need = int'(v[0]) + int'(v[1]);
    fc = 0;
    for (int i = 0; i < NUM_PHYS; i++) fc += int'(m_free[i]);
    exp_rdy = (fc >= need);
    #1;
    chk(dec_ready_o == exp_rdy, "R8", "dec_ready", int'(dec_ready_o), int'(exp_rdy));

    for (int i = 0; i < NUM_LOG; i++) begin tmap[i] = m_map[i]; fr[i] = -1; end
    for (int i = 0; i < NUM_PHYS; i++) tf[i] = m_free[i];
    for (int k = 0; k < 2; k++) begin
      e1[k] = 0; e2[k] = 0; er[k] = 0;
      if (exp_rdy && v[k]) begin
        if (fr[sa[k]] >= 0) e1[k] = 8 + fr[sa[k]];
        else if (m_rdy[m_map[sa[k]]] || (wbv && wbp == m_map[sa[k]])) e1[k] = m_map[sa[k]];
        else e1[k] = 8 + m_fu[m_map[sa[k]]];
        if (fr[sb[k]] >= 0) e2[k] = 8 + fr[sb[k]];
        else if (m_rdy[m_map[sb[k]]] || (wbv && wbp == m_map[sb[k]])) e2[k] = m_map[sb[k]];
        else e2[k] = 8 + m_fu[m_map[sb[k]]];
        er[k] = -1;
        for (int i = NUM_PHYS - 1; i >= 0; i--) if (tf[i]) er[k] = i;
        tf[er[k]] = 1'b0;
        tmap[dd[k]] = er[k];
        fr[dd[k]] = fu[k];
      end
    end
    if (exp_rdy && v != 0) begin
      for (int i = 0; i < NUM_LOG; i++) m_map[i] = tmap[i];
      for (int i = 0; i < NUM_PHYS; i++) m_free[i] = tf[i];
      for (int k = 0; k < 2; k++) if (v[k]) begin
        m_rdy[er[k]] = 1'b0;
        m_fu[er[k]]  = fu[k];
        ql[qt % 64] = dd[k];
        qp[qt % 64] = er[k];
        qt++;
      end
    end
    if (wbv) m_rdy[wbp] = 1'b1;
    if (do_cmt) begin
      m_free[m_cmap[cl]] = 1'b1;
      m_cmap[cl] = cp;
      qh++;
    end

    @(posedge clk);
    @(negedge clk);
    chk(disp_valid_o == (exp_rdy ? v : 2'b00), "R10", "disp_valid",
        int'(disp_valid_o), int'(exp_rdy ? v : 2'b00));
    for (int k = 0; k < 2; k++) begin
      if (exp_rdy && v[k]) begin
        chk(int'(disp_fu_o[k]) == fu[k], "R10", "disp_fu", int'(disp_fu_o[k]), fu[k]);
        chk(int'(disp_res_o[k]) == er[k], "R4", "disp_res", int'(disp_res_o[k]), er[k]);
        chk(int'(disp_op1_o[k]) == e1[k], rq, "disp_op1", int'(disp_op1_o[k]), e1[k]);
        chk(int'(disp_op2_o[k]) == e2[k], rq, "disp_op2", int'(disp_op2_o[k]), e2[k]);
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    #1;
    chk(dec_ready_o == 1'b1, "R1", "ready after reset", int'(dec_ready_o), 1);
    chk(disp_valid_o == 2'b00, "R1", "valid after reset", int'(disp_valid_o), 0);
    @(negedge clk);

    // R1 R2: reset mapping read as present registers
    step(2'b01, 2, 0, 3, 1,  0, 0, 0, 0,  0, 0, 0, "R1 R2");
    // R5 R3 in slot 0, R6 forwarding into slot 1
    step(2'b11, 0, 1, 1, 1,  1, 1, 2, 2,  0, 0, 0, "R5 R6 R3");
    // R7: S5 written back while being read; S6 still awaited (R3)
    step(2'b01, 2, 1, 2, 3,  0, 0, 0, 0,  1, 5, 0, "R7 R3");
    // R8: pool empty
    step(2'b01, 1, 0, 0, 0,  0, 0, 0, 0,  0, 0, 0, "R8");
    // R9: commit frees a register, unusable in the same cycle
    step(2'b01, 1, 0, 0, 0,  0, 0, 0, 0,  0, 0, 1, "R9");
    // R8: one free, two requested
    step(2'b11, 0, 3, 3, 2,  1, 1, 0, 0,  0, 0, 0, "R8");
    // R9: freed register now handed out
    step(2'b10, 0, 0, 0, 0,  2, 1, 3, 0,  1, 4, 0, "R9 R2");
    step(2'b00, 0, 0, 0, 0,  0, 0, 0, 0,  0, 0, 1, "R9");

    lf = 16'hACE1;
    for (int it = 0; it < 1500; it++) begin
      logic [15:0] a, b;
      int wbp;
      bit wbv;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      a = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      b = lf;
      wbp = int'(b[4:2]);
      wbv = !m_free[wbp] && !m_rdy[wbp];
      step(a[1:0],
           int'(a[3:2]) % 3, int'(a[5:4]), int'(a[7:6]), int'(a[9:8]),
           int'(a[11:10]) % 3, int'(a[13:12]), int'(a[15:14]), int'(b[9:8]),
           wbv, wbp, b[0] | b[1], "R2 R3 R6 R7");
    end

    dec_valid_i = '0;
    wb_valid_i  = 1'b0;
    cmt_valid_i = 1'b0;
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule